// File: doc/BRIEF.md
# Synchronous Graphics DRAM Power-Up Sequencer

This controller-side block carries a synchronous graphics DRAM from power-on to the point where normal traffic may begin. After reset it holds clock enable and the data mask high and keeps every command cycle idle for a stable interval. The interval length in clock cycles comes in on an input. It then closes every bank with a single precharge, performs a minimum number of auto-refresh cycles and loads the mode register. As an option it also loads the special (colour/mask) mode register. A timed idle gap follows every command. When the last gap has run out, the block raises a completion flag and holds it until the next reset.

The refresh group and the mode-register load can run in either order, chosen by a parameter. A special-register word that asks to load both the colour and the mask register at once is refused: that command is dropped and an error flag is raised. The sequencer is a single Moore state machine with the states ARM, WAIT, PRE, PRE_GAP, REF, REF_GAP, MRS, MRS_GAP, SMR, SMR_GAP and DONE. Its transitions are:

- ARM to WAIT: always.
- WAIT to PRE: the idle timer expires.
- PRE to PRE_GAP, REF to REF_GAP, MRS to MRS_GAP and SMR to SMR_GAP: always.
- PRE_GAP to REF or MRS: depends on the order parameter.
- REF_GAP to REF: refreshes remain.
- REF_GAP or MRS_GAP to the next group: the group is finished. The next group is MRS, REF, SMR or DONE.
- SMR_GAP to DONE: always.

Top module: `dram_boot_seq`

## Requirements
- R1: While reset is low, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). During reset, addr and ba are 0, and init_done and smr_err are 0. cke is 1 at all times. dqm is 1 until init_done is 1 and 0 from then on.
- R2: Only NOP is issued after reset release until the first command. That command appears on rising edge max(wait_cycles,1)+1, counting the first edge with rst_n high as edge 1. wait_cycles is taken at edge 1.
- R3: The first command is precharge-all: ras_n=0, cas_n=1, we_n=0, addr bit 8 set, every other addr bit 0, and ba=0.
- R4: Auto-refresh (ras_n=0, cas_n=0, we_n=1) is issued exactly max(REF_COUNT,2) times.
- R5: The mode-register load drives ras_n, cas_n and we_n all low with ba=0. Its addr equals mode_word with bit 10 forced to 0.
- R6: After a precharge the next event comes max(T_RP,1)+1 edges later. After a refresh it comes max(T_RC,1)+1 edges later. After either register load it comes max(T_MRD,1)+1 edges later. Every cycle between events is NOP.
- R7: With MRS_FIRST=0 all refreshes come before the mode-register load. With MRS_FIRST=1 the mode-register load comes before the refreshes.
- R8: With SMR_EN=1 a special-register load follows both groups: ras_n, cas_n and we_n low, ba all ones, addr=smr_word. If smr_word bits 6 and 5 are both 1, this load is not issued, and smr_err and init_done rise on the same edge. smr_err then holds until reset.
- R9: init_done rises on the edge that ends the gap of the last command. It stays 1 until reset, and only NOP is issued while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_cycles | input | CNT_W | Length of the stable idle interval in cycles |
| mode_word | input | ADDR_W | Word to load into the mode register |
| smr_word | input | ADDR_W | Word to load into the special mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | Initialization complete |
| smr_err | output | 1 | Conflicting special-register word was refused |

## Verification
Two events can coincide on one edge: refusing a special-register word and completing the sequence. Both are decided where the last group's gap expires. The bench provokes this by presenting a word with both bit 6 and bit 5 set. It then requires three things:
- smr_err and init_done first read 1 at the same sampled edge.
- That edge is the end of the mode-register (or last refresh) gap.
- No special-register command appears anywhere in the trace.

A clean word in the other scenarios must give the opposite result: the load is issued, and smr_err stays 0.

// File: rtl/dram_boot_pkg.sv
package dram_boot_pkg;

    typedef enum logic [3:0] {
        S_ARM,
        S_WAIT,
        S_PRE,
        S_PRE_GAP,
        S_REF,
        S_REF_GAP,
        S_MRS,
        S_MRS_GAP,
        S_SMR,
        S_SMR_GAP,
        S_DONE
    } boot_state_t;

    typedef enum logic [2:0] {
        C_NOP,
        C_PRE,
        C_REF,
        C_MRS,
        C_SMR
    } boot_cmd_t;

    // address bit positions the memory decodes
    localparam int RSV_BIT = 10;  // must be 0 during a mode load
    localparam int AP_BIT  = 8;   // all-bank precharge select
    localparam int LC_BIT  = 6;   // special register: load colour
    localparam int LM_BIT  = 5;   // special register: load mask

endpackage

// File: rtl/boot_cmd_enc.sv
module boot_cmd_enc
    import dram_boot_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 1
) (
    input  boot_cmd_t           cmd,
    input  logic [ADDR_W-1:0]   mode_word,
    input  logic [ADDR_W-1:0]   smr_word,
    output logic                cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [BA_W-1:0]     ba
);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        ba    = '0;
        unique case (cmd)
            C_NOP: begin
            end
            C_PRE: begin
                ras_n        = 1'b0;
                we_n         = 1'b0;
                addr[AP_BIT] = 1'b1;
            end
            C_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            C_MRS: begin
                ras_n         = 1'b0;
                cas_n         = 1'b0;
                we_n          = 1'b0;
                addr          = mode_word;
                addr[RSV_BIT] = 1'b0;
            end
            C_SMR: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = smr_word;
                ba    = '1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/boot_ref_counter.sv
module boot_ref_counter #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dram_boot_seq.sv
module dram_boot_seq
    import dram_boot_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 11,
    parameter int BA_W      = 1,
    parameter int REF_COUNT = 2,
    parameter int T_RP      = 3,
    parameter int T_RC      = 10,
    parameter int T_MRD     = 2,
    parameter bit MRS_FIRST = 1'b0,
    parameter bit SMR_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  wait_cycles,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] smr_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              smr_err
);

    localparam int REFS   = (REF_COUNT < 2) ? 2 : REF_COUNT;
    localparam int RCW    = $clog2(REFS + 1);
    localparam int G_RP   = (T_RP  < 1) ? 1 : T_RP;
    localparam int G_RC   = (T_RC  < 1) ? 1 : T_RC;
    localparam int G_MRD  = (T_MRD < 1) ? 1 : T_MRD;

    boot_state_t      state_q, state_d, tail_st;
    boot_cmd_t        cmd;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic [RCW-1:0]   ref_cnt;
    logic             refs_left;
    logic             smr_bad, err_set, smr_err_q;

    assign smr_bad   = smr_word[LC_BIT] & smr_word[LM_BIT];
    assign tail_st   = (SMR_EN && !smr_bad) ? S_SMR : S_DONE;
    assign refs_left = (ref_cnt != RCW'(REFS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARM:     state_d = S_WAIT;
            S_WAIT:    if (tmr_expired) state_d = S_PRE;
            S_PRE:     state_d = S_PRE_GAP;
            S_PRE_GAP: if (tmr_expired) state_d = MRS_FIRST ? S_MRS : S_REF;
            S_REF:     state_d = S_REF_GAP;
            S_REF_GAP: begin
                if (tmr_expired) begin
                    if (refs_left)      state_d = S_REF;
                    else if (MRS_FIRST) state_d = tail_st;
                    else                state_d = S_MRS;
                end
            end
            S_MRS:     state_d = S_MRS_GAP;
            S_MRS_GAP: if (tmr_expired) state_d = MRS_FIRST ? S_REF : tail_st;
            S_SMR:     state_d = S_SMR_GAP;
            S_SMR_GAP: if (tmr_expired) state_d = S_DONE;
            S_DONE:    state_d = S_DONE;
            default:   state_d = S_ARM;
        endcase
    end

    // outputs and timer loads
    always_comb begin
        cmd      = C_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_ARM: begin
                tmr_load = 1'b1;
                tmr_val  = (wait_cycles == '0) ? '0 : wait_cycles - 1'b1;
            end
            S_PRE: begin
                cmd      = C_PRE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(G_RP - 1);
            end
            S_REF: begin
                cmd      = C_REF;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(G_RC - 1);
            end
            S_MRS: begin
                cmd      = C_MRS;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(G_MRD - 1);
            end
            S_SMR: begin
                cmd      = C_SMR;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(G_MRD - 1);
            end
            default: begin
            end
        endcase
    end

    assign err_set = SMR_EN && smr_bad && (state_d == S_DONE) &&
                     ((state_q == S_REF_GAP) || (state_q == S_MRS_GAP));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smr_err_q <= 1'b0;
        end else if (err_set) begin
            smr_err_q <= 1'b1;
        end
    end

    boot_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    boot_ref_counter #(.CW(RCW)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (state_q == S_REF),
        .count (ref_cnt)
    );

    boot_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .cmd       (cmd),
        .mode_word (mode_word),
        .smr_word  (smr_word),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba)
    );

    assign cke       = 1'b1;
    assign init_done = (state_q == S_DONE);
    assign dqm       = (state_q != S_DONE);
    assign smr_err   = smr_err_q;

endmodule

// File: rtl/dram_boot_chk.sv
module dram_boot_chk #(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              cke,
    input logic              dqm,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done,
    input logic              smr_err
);

    logic is_nop, is_pre, is_mrs, is_smr;

    assign is_nop = !cs_n && ras_n && cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n && (ba == '0);
    assign is_smr = !cs_n && !ras_n && !cas_n && !we_n && (ba == '1);

    a_r1_mask_high: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (cke && dqm));

    a_r3_prech_all: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[8]);

    a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> !addr[10]);

    a_r6_gap_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    a_r8_no_dual_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_smr |-> !(addr[6] && addr[5]));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        smr_err |=> smr_err);

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind dram_boot_seq dram_boot_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke       (cke),
    .dqm       (dqm),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done),
    .smr_err   (smr_err)
);

// File: tb/sim_dram_boot_seq.sv
`timescale 1ns/1ps
module sim_dram_boot_seq;

    localparam int AW   = 11;
    localparam int CW   = 16;
    localparam int TRP  = 2;
    localparam int TRC  = 3;
    localparam int TMRD = 2;
    localparam int NS   = 80;
    localparam int REFS0 = 3;
    localparam int REFS1 = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] wait_cycles = '0;
    logic [AW-1:0] mode_word = '0;
    logic [AW-1:0] smr_word = '0;

    logic [1:0]    cs_n, ras_n, cas_n, we_n, cke, dqm, ba, done, err;
    logic [AW-1:0] addr_o [2];

    always #2 clk = ~clk;

    dram_boot_seq #(.CNT_W(CW), .ADDR_W(AW), .BA_W(1), .REF_COUNT(REFS0),
        .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .MRS_FIRST(1'b0), .SMR_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .mode_word(mode_word),
        .smr_word(smr_word), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]),
        .we_n(we_n[0]), .cke(cke[0]), .dqm(dqm[0]), .addr(addr_o[0]), .ba(ba[0:0]),
        .init_done(done[0]), .smr_err(err[0]));

    dram_boot_seq #(.CNT_W(CW), .ADDR_W(AW), .BA_W(1), .REF_COUNT(REFS1),
        .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .MRS_FIRST(1'b1), .SMR_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .mode_word(mode_word),
        .smr_word(smr_word), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]),
        .we_n(we_n[1]), .cke(cke[1]), .dqm(dqm[1]), .addr(addr_o[1]), .ba(ba[1:1]),
        .init_done(done[1]), .smr_err(err[1]));

    int checks = 0;
    int fails  = 0;

    int tr [2][NS];
    int ad [2][NS];
    int bk [2][NS];
    int dn [2][NS];
    int er [2][NS];
    int dq [2][NS];
    int ck [2][NS];

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // 0 NOP, 1 precharge, 2 refresh, 3 mode load, 4 special load, 5 other
    function automatic int dec(input int i);
        logic [3:0] p;
        p = {cs_n[i], ras_n[i], cas_n[i], we_n[i]};
        if (p == 4'b0111) return 0;
        if (p == 4'b0010) return 1;
        if (p == 4'b0001) return 2;
        if (p == 4'b0000) return (ba[i] == 1'b0) ? 3 : 4;
        return 5;
    endfunction

    task automatic run(input int w, input logic [AW-1:0] mw, input logic [AW-1:0] sw);
        wait_cycles = CW'(w);
        mode_word   = mw;
        smr_word    = sw;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk("R1", "reset command", dec(i), 0);
            chk("R1", "reset addr", int'(addr_o[i]), 0);
            chk("R1", "reset ba", int'(ba[i]), 0);
            chk("R1", "reset cke", int'(cke[i]), 1);
            chk("R1", "reset dqm", int'(dqm[i]), 1);
            chk("R1", "reset done", int'(done[i]), 0);
            chk("R8", "reset err", int'(err[i]), 0);
        end
        rst_n = 1'b1;
        for (int k = 1; k < NS; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                tr[i][k] = dec(i);
                ad[i][k] = int'(addr_o[i]);
                bk[i][k] = int'(ba[i]);
                dn[i][k] = int'(done[i]);
                er[i][k] = int'(err[i]);
                dq[i][k] = int'(dqm[i]);
                ck[i][k] = int'(cke[i]);
            end
        end
    endtask

    task automatic check_inst(input int i, input int w, input int refs, input int mfirst,
                              input logic [AW-1:0] mw, input logic [AW-1:0] sw);
        int e [NS];
        int p, done_at, first, mrs_i, ref_i, smr_i, nref, nsmr, dev, drise, erise, dqbad;
        bit bad;
        for (int k = 0; k < NS; k++) e[k] = 0;
        bad = sw[6] & sw[5];
        p = ((w < 1) ? 1 : w) + 1;
        e[p] = 1; p += TRP + 1;
        if (mfirst != 0) begin
            e[p] = 3; p += TMRD + 1;
            for (int r = 0; r < refs; r++) begin e[p] = 2; p += TRC + 1; end
        end else begin
            for (int r = 0; r < refs; r++) begin e[p] = 2; p += TRC + 1; end
            e[p] = 3; p += TMRD + 1;
        end
        if (!bad) begin e[p] = 4; p += TMRD + 1; end
        done_at = p;

        first = -1; mrs_i = -1; ref_i = -1; smr_i = -1; nref = 0; nsmr = 0;
        dev = -1; drise = -1; erise = -1; dqbad = 0;
        for (int k = 1; k < NS; k++) begin
            if (first < 0 && tr[i][k] != 0) first = k;
            if (tr[i][k] == 2) begin nref++; if (ref_i < 0) ref_i = k; end
            if (tr[i][k] == 3 && mrs_i < 0) mrs_i = k;
            if (tr[i][k] == 4) begin nsmr++; smr_i = k; end
            if (dev < 0 && tr[i][k] != e[k]) dev = k;
            if (drise < 0 && dn[i][k] == 1) drise = k;
            if (erise < 0 && er[i][k] == 1) erise = k;
            if (dq[i][k] != (1 - dn[i][k]) || ck[i][k] != 1) dqbad++;
            if (drise >= 0 && dn[i][k] != 1) dqbad++;
        end

        chk("R2", "first command edge", first, ((w < 1) ? 1 : w) + 1);
        chk("R3", "first command kind", (first > 0) ? tr[i][first] : -1, 1);
        chk("R3", "precharge addr", (first > 0) ? ad[i][first] : -1, 256);
        chk("R3", "precharge ba", (first > 0) ? bk[i][first] : -1, 0);
        chk("R4", "refresh count", nref, refs);
        chk("R6", "first deviating edge", dev, -1);
        chk("R5", "mode load addr", (mrs_i > 0) ? ad[i][mrs_i] : -1, int'(mw & ~11'h400));
        chk("R7", "mode load before refresh", int'(mrs_i < ref_i), mfirst);
        chk("R8", "special load count", nsmr, bad ? 0 : 1);
        if (!bad) begin
            chk("R8", "special addr", (smr_i > 0) ? ad[i][smr_i] : -1, int'(sw));
            chk("R8", "special ba", (smr_i > 0) ? bk[i][smr_i] : -1, 1);
            chk("R8", "error flag clean", er[i][NS-1], 0);
        end else begin
            chk("R8", "error flag set", er[i][NS-1], 1);
            chk("R8", "error with done edge", erise, drise);
        end
        chk("R9", "done rise edge", drise, done_at);
        chk("R1", "cke/dqm/done hold mismatches", dqbad, 0);
    endtask

    task automatic t_nominal();
        run(6, 11'h7A5, 11'h040);
        check_inst(0, 6, REFS0, 0, 11'h7A5, 11'h040);
        check_inst(1, 6, REFS1, 1, 11'h7A5, 11'h040);
    endtask

    task automatic t_wait_floor();
        run(0, 11'h032, 11'h020);
        check_inst(0, 0, REFS0, 0, 11'h032, 11'h020);
        check_inst(1, 0, REFS1, 1, 11'h032, 11'h020);
    endtask

    task automatic t_wait_long();
        run(12, 11'h7FF, 11'h000);
        check_inst(0, 12, REFS0, 0, 11'h7FF, 11'h000);
        check_inst(1, 12, REFS1, 1, 11'h7FF, 11'h000);
    endtask

    task automatic t_bad_special();
        run(4, 11'h023, 11'h060);
        check_inst(0, 4, REFS0, 0, 11'h023, 11'h060);
        check_inst(1, 4, REFS1, 1, 11'h023, 11'h060);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_nominal();
        t_wait_floor();
        t_wait_long();
        t_bad_special();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule